// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI controller from the faster module clock. One configuration word carries two divisor fields and a law-select bit: with the select bit set, the low 8-bit field `n` sets a linear ratio of 2·(n+1), from 2 up to 512. With the select bit clear, a 4-bit exponent `e` placed above it sets a power-of-two ratio of 2^(e+1). Only the field picked by the select bit has any effect.

The output clock has an even duty cycle. Its level toggles once every half-period of module cycles, and a one-cycle marker tells the shift engine in which cycle each edge happened. When no burst is running, the clock rests at the configured idle polarity. A burst-start pulse restarts the half-period counter, so the first phase of a burst always has its full length. A change to the effective divisor or to the idle polarity in mid-burst has the same restarting effect.

Top module: `sclk_divgen`

## Requirements
- R1: With `cfg_i[12]` = 1, the half-period is `cfg_i[7:0]` + 1 module cycles, and `sclk_o` first toggles that many cycles after the restart edge.
- R2: With `cfg_i[12]` = 0, the half-period is 2^`cfg_i[11:8]` module cycles.
- R3: The field that the select bit does not pick has no effect: changing it while a burst runs neither restarts nor retimes the clock.
- R4: Both half-periods are equal (even duty), and every following half-period keeps the same length.
- R5: At the edge where `start_i` is high with `run_i` high, `sclk_o` takes the `cpol_i` level, `tick_o` is low, and the next toggle comes one full half-period later.
- R6: While `run_i` is low, `sclk_o` equals the `cpol_i` level of the previous cycle and `tick_o` is low.
- R7: A change of the effective divisor or of `cpol_i` during a burst restarts the clock exactly as R5 does.
- R8: `tick_o` is high in exactly the cycles in which `sclk_o` took a new level through a toggle.
- R9: During synchronous reset, `sclk_o` follows `cpol_i` and `tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_i | input | 13 | Divider word: [7:0] linear field, [11:8] exponent, [12] law select (1 = linear) |
| cpol_i | input | 1 | Idle level of the serial clock |
| run_i | input | 1 | High while a burst is in progress |
| start_i | input | 1 | One-cycle burst-start pulse |
| sclk_o | output | 1 | Registered serial clock |
| tick_o | output | 1 | Registered marker, high in the cycle after each toggle edge |

## Verification
The assertions assume that the controlling logic drives `cfg_i`, `cpol_i`, `run_i` and `start_i` synchronously to `clk`. They also assume that a divisor change only ever reaches the counter together with a restart. The stimulus keeps to this by changing inputs only at falling clock edges. It holds the configuration steady during each measured interval, except for deliberate changes of a whole word, of the idle level, or of the unused field. The exponent stays at 10 or below, so every measured interval remains short.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic {
    LAW_EXP = 1'b0,
    LAW_LIN = 1'b1
  } law_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdiv_cfg_stage.sv
module sdiv_cfg_stage
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CFG_W = LIN_W + EXP_W + 1,
  parameter int LIM_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             cpol_i,
  input  logic             start_i,
  output logic [LIM_W-1:0] lim_o,
  output logic             restart_o
);
  localparam int SEL_B = LIN_W + EXP_W;

  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_n;
  law_e             law;
  logic [LIM_W:0]   pow;
  logic [LIM_W-1:0] lim_next;
  logic [LIM_W-1:0] lim_q;
  logic             cpol_q;
  logic [CFG_W-1:0] cfg_q;

  always_comb begin
    lin_n = cfg_i[LIN_W-1:0];
    exp_n = cfg_i[LIN_W +: EXP_W];
    law   = law_e'(cfg_i[SEL_B]);
    pow   = {{LIM_W{1'b0}}, 1'b1} << exp_n;
    if (law == LAW_LIN) lim_next = LIM_W'(lin_n);
    else                lim_next = pow[LIM_W-1:0] - 1'b1;
  end

  // Effective settings are tracked every cycle; a mismatch means a change.
  always_ff @(posedge clk) begin
    lim_q  <= lim_next;
    cpol_q <= cpol_i;
    cfg_q  <= cfg_i;
    if (rst) begin
      lim_q  <= lim_next;
      cpol_q <= cpol_i;
    end
  end

  assign restart_o = start_i | (lim_next != lim_q) | (cpol_i != cpol_q);
  assign lim_o     = lim_q;

  // R3
  keep_field_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[SEL_B] && cfg_i[SEL_B] && (cfg_i[LIN_W-1:0] == cfg_q[LIN_W-1:0])
     && (cpol_i == cpol_q) && !start_i) |-> !restart_o)
    else $error("unused field caused a restart");
endmodule

// File: rtl/sdiv_half_cnt.sv
module sdiv_half_cnt #(
  parameter int LIM_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             wrap_o
);
  logic [LIM_W-1:0] cnt_q;

  assign wrap_o = run_i && !restart_i && (cnt_q == lim_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i || wrap_o) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_i)
    else $error("half-period counter beyond limit");
endmodule

// File: rtl/sdiv_phase_out.sv
module sdiv_phase_out (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic restart_i,
  input  logic wrap_i,
  input  logic cpol_i,
  output logic sclk_o,
  output logic tick_o
);
  logic sclk_q;
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) begin
      sclk_q <= cpol_i;
      tick_q <= 1'b0;
    end else if (wrap_i) begin
      sclk_q <= ~sclk_q;
      tick_q <= 1'b1;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;
  assign tick_o = tick_q;

  // R8
  tick_edge_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (sclk_q != $past(sclk_q)))
    else $error("tick without a clock edge");
endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LIN_W+EXP_W:0]     cfg_i,
  input  logic                     cpol_i,
  input  logic                     run_i,
  input  logic                     start_i,
  output logic                     sclk_o,
  output logic                     tick_o
);
  localparam int CFG_W = LIN_W + EXP_W + 1;
  localparam int LIM_W = imax(LIN_W, (1 << EXP_W) - 1);

  logic [LIM_W-1:0] lim;
  logic             restart;
  logic             wrap;

  sdiv_cfg_stage #(
    .LIN_W(LIN_W), .EXP_W(EXP_W), .CFG_W(CFG_W), .LIM_W(LIM_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .cpol_i(cpol_i),
    .start_i(start_i), .lim_o(lim), .restart_o(restart)
  );

  sdiv_half_cnt #(.LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(run_i), .restart_i(restart),
    .lim_i(lim), .wrap_o(wrap)
  );

  sdiv_phase_out u_out (
    .clk(clk), .rst(rst), .run_i(run_i), .restart_i(restart),
    .wrap_i(wrap), .cpol_i(cpol_i), .sclk_o(sclk_o), .tick_o(tick_o)
  );

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> ((sclk_o == $past(cpol_i)) && !tick_o))
    else $error("idle level wrong");

  // R5 R7
  restart_level_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && restart) |=> ((sclk_o == $past(cpol_i)) && !tick_o))
    else $error("restart did not return to idle level");
endmodule

// File: tb/sim_sclk_divgen.sv
module sim_sclk_divgen;
  localparam int CLK_NS = 10;
  localparam int NV = 9;
  localparam logic [12:0] V_CFG [NV] = '{13'h1000, 13'h1001, 13'h1004, 13'h10FF,
                                         13'h1F07, 13'h0000, 13'h0100, 13'h03AA,
                                         13'h0A00};
  localparam int V_HALF [NV] = '{1, 2, 5, 256, 8, 1, 2, 8, 1024};
  localparam bit V_POL  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [12:0] cfg = '0;
  logic cpol = 1'b0;
  logic run = 1'b0;
  logic start = 1'b0;
  logic sclk, tick;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sclk_divgen u0 (
    .clk(clk), .rst(rst), .cfg_i(cfg), .cpol_i(cpol), .run_i(run),
    .start_i(start), .sclk_o(sclk), .tick_o(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic lvl, output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (sclk == lvl && c < 5000);
  endtask

  task automatic begin_burst(input logic [12:0] w, input logic p);
    cfg = w; cpol = p; run = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int c;
    // R9: reset state follows the idle level
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R9", sclk, 1);
    chk(tick == 1'b0, "R9", tick, 0);
    cpol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R9", sclk, 0);
    rst = 1'b0;

    // Table walk: R1 linear, R2 exponential, R3 unused field, R4 duty
    for (int i = 0; i < NV; i++) begin
      run = 1'b0; cfg = V_CFG[i]; cpol = V_POL[i];
      repeat (2) @(negedge clk);
      chk(sclk == V_POL[i], "R6", sclk, V_POL[i]);
      chk(tick == 1'b0, "R6", tick, 0);
      begin_burst(V_CFG[i], V_POL[i]);
      chk(sclk == V_POL[i], "R5", sclk, V_POL[i]);
      wait_level(V_POL[i], c);
      chk(c == V_HALF[i], V_CFG[i][12] ? "R1" : "R2", c, V_HALF[i]);
      chk(tick == 1'b1, "R8", tick, 1);
      wait_level(!V_POL[i], c);
      chk(c == V_HALF[i], "R4", c, V_HALF[i]);
      wait_level(V_POL[i], c);
      chk(c == V_HALF[i], "R4", c, V_HALF[i]);
    end

    // R8: tick low between edges (half = 5)
    begin_burst(13'h1004, 1'b0);
    wait_level(1'b0, c);
    @(negedge clk);
    chk(tick == 1'b0, "R8", tick, 0);

    // R6: idle drops the clock to the idle level
    run = 1'b0; cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R6", sclk, 1);
    chk(tick == 1'b0, "R6", tick, 0);

    // R7: divisor change mid-burst restarts with the new half-period
    begin_burst(13'h1009, 1'b0);
    wait_level(1'b0, c);
    repeat (3) @(negedge clk);
    cfg = 13'h1002;
    @(negedge clk);
    chk(sclk == 1'b0, "R7", sclk, 0);
    wait_level(1'b0, c);
    chk(c == 3, "R7", c, 3);

    // R7: idle-level change mid-burst restarts
    run = 1'b0; @(negedge clk);
    begin_burst(13'h1009, 1'b0);
    wait_level(1'b0, c);
    repeat (3) @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R7", sclk, 1);
    wait_level(1'b1, c);
    chk(c == 10, "R7", c, 10);

    // R3: touching the linear field in exponential mode changes nothing
    run = 1'b0; @(negedge clk);
    begin_burst(13'h0200, 1'b0);
    wait_level(1'b0, c);
    cfg = 13'h02FF;
    wait_level(1'b1, c);
    chk(c == 4, "R3", c, 4);

    // R5: a start pulse in mid-burst restarts from the idle level
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(sclk == 1'b0, "R5", sclk, 0);
    wait_level(1'b0, c);
    chk(c == 4, "R5", c, 4);

    finish_up();
  end
endmodule